// File: doc/BRIEF.md
# Float-versus-integer compare unit

This unit compares the value at the top of a floating-point register stack, held in double extended-precision layout (sign, biased exponent, explicit-integer-bit significand), against a signed integer operand. The integer is either the full operand width or a narrower field taken from its low bits. It reports the relation as a three-bit condition code and raises exception flags for invalid operands, denormal operands and an empty stack slot. A pop variant also asks the stack to release its top register and gives back the advanced stack pointer.

The integer is widened exactly into the floating-point layout before the compare. Its magnitude is formed first, so the most negative value is exact. A leading-zero count then normalises it into the significand. The compare is unordered: a NaN, an unsupported encoding or an empty slot yields the all-ones code. Zeros of either sign match integer zero. A denormal operand raises its flag but leaves the ordering unchanged.

A start strobe launches one compare. All results are registered and appear with a one-cycle valid pulse on the next clock edge. A synchronous reset clears every output.

Top module: `flt_int_cmp`

## Requirements
- R1: For ordered operands the code {condC3,condC2,condC0} is 000 when the stack value is greater than the integer, 001 when it is less, and 100 when they are equal.
- R2: With wideSel=1 the whole intOperand is read as two's complement. With wideSel=0 only the low NARROW_W bits are used, sign-extended, and the upper bits have no effect. Every value, including the most negative one, compares exactly.
- R3: A NaN (all-ones exponent, integer bit 1, nonzero fraction) or an unsupported encoding (nonzero exponent with integer bit 0) gives code 111 with exInvalid=1.
- R4: Positive and negative zero both compare equal to integer zero, giving code 100.
- R5: A denormal stack value (zero exponent, nonzero significand) sets exDenormal=1, and the code still reflects its true ordering.
- R6: When stEmpty=1 the code is 111, exUnderflow=1, and exInvalid and exDenormal are 0.
- R7: condC1 is 0 on every result.
- R8: With popSel=1 a result carries popReq=1 and nextTop = topIn+1 modulo 8. With popSel=0, popReq=0 and nextTop = topIn.
- R9: Positive infinity (all-ones exponent, integer bit 1, zero fraction) is greater than any integer, and negative infinity is less.
- R10: resValid rises in the cycle after a start strobe and is 0 in a cycle that follows no strobe. popReq is never 1 without resValid. A synchronous reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launches one compare |
| stValue | input | 1+EXP_W+MAN_W | Top-of-stack value: sign, biased exponent, significand |
| stEmpty | input | 1 | Top-of-stack register is tagged empty |
| topIn | input | 3 | Current stack pointer |
| intOperand | input | INT_W | Integer operand |
| wideSel | input | 1 | 1: full-width integer, 0: low NARROW_W bits |
| popSel | input | 1 | 1: compare and pop, 0: compare only |
| resValid | output | 1 | Result valid pulse |
| condC3 | output | 1 | Condition bit C3 |
| condC2 | output | 1 | Condition bit C2 |
| condC1 | output | 1 | Condition bit C1 (always 0) |
| condC0 | output | 1 | Condition bit C0 |
| exInvalid | output | 1 | NaN or unsupported encoding seen |
| exDenormal | output | 1 | Denormal stack value seen |
| exUnderflow | output | 1 | Stack slot was empty |
| popReq | output | 1 | Request to release the top register |
| nextTop | output | 3 | Stack pointer after the operation |

## Verification
The bench builds the unit with a 4-bit exponent, an 8-bit significand, an 8-bit integer and a 4-bit narrow field. In this configuration every one of the 8192 stack encodings can be swept against several integers: the extremes, zero, the integer part of the value itself (which makes equal cases common) and narrow-width operands. The second sweep runs every integer pattern in both widths against zeros, infinities, a NaN, a denormal and exact integers. The bench takes expected results from scaled integer arithmetic on the encodings, with no reuse of the unit's key-compare logic.

// File: rtl/flt_cmp_pkg.sv
package flt_cmp_pkg;

  typedef struct packed {
    logic load;
    logic doPop;
  } ctrlStrobe_t;

  typedef enum logic [2:0] {
    CODE_GT = 3'b000,
    CODE_LT = 3'b001,
    CODE_EQ = 3'b100,
    CODE_UN = 3'b111
  } cmpCode_t;

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_DENORM,
    CLS_NORMAL,
    CLS_INF,
    CLS_NAN,
    CLS_UNSUP
  } fltClass_t;

endpackage

// File: rtl/flt_cmp_classify.sv
module flt_cmp_classify
  import flt_cmp_pkg::*;
#(
  parameter int EXP_W = 15,
  parameter int MAN_W = 64
) (
  input  logic [EXP_W-1:0] expIn,
  input  logic [MAN_W-1:0] manIn,
  output fltClass_t        cls,
  output logic [EXP_W-1:0] effExp
);

  logic intBit;
  logic fracZero;
  logic expMax;
  logic expZero;

  always_comb begin
    intBit   = manIn[MAN_W-1];
    fracZero = (manIn[MAN_W-2:0] == '0);
    expMax   = &expIn;
    expZero  = (expIn == '0);

    if (expZero) begin
      cls = (intBit || !fracZero) ? CLS_DENORM : CLS_ZERO;
    end else if (!intBit) begin
      cls = CLS_UNSUP;
    end else if (expMax) begin
      cls = fracZero ? CLS_INF : CLS_NAN;
    end else begin
      cls = CLS_NORMAL;
    end

    effExp = expZero ? EXP_W'(1) : expIn;
  end

endmodule

// File: rtl/flt_cmp_widen.sv
module flt_cmp_widen #(
  parameter int EXP_W    = 15,
  parameter int MAN_W    = 64,
  parameter int INT_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic [INT_W-1:0] rawInt,
  input  logic             wideSel,
  output logic             negOut,
  output logic             zeroOut,
  output logic [EXP_W-1:0] expOut,
  output logic [MAN_W-1:0] manOut
);

  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int LZ_W  = $clog2(INT_W) + 1;
  localparam int TOP_E = BIAS + INT_W - 1;

  logic [INT_W-1:0] extInt;
  logic [INT_W-1:0] magInt;
  logic [LZ_W-1:0]  lzCount;
  logic [MAN_W-1:0] aligned;

  always_comb begin
    extInt = wideSel ? rawInt
                     : {{(INT_W-NARROW_W){rawInt[NARROW_W-1]}}, rawInt[NARROW_W-1:0]};
    negOut = extInt[INT_W-1];
    // Unsigned magnitude: the most negative value maps to 2^(INT_W-1) exactly.
    magInt = negOut ? (~extInt + 1'b1) : extInt;
  end

  always_comb begin
    lzCount = LZ_W'(INT_W);
    for (int i = 0; i < INT_W; i++) begin
      if (magInt[i]) lzCount = LZ_W'(INT_W - 1 - i);
    end
  end

  always_comb begin
    zeroOut = (magInt == '0);
    aligned = MAN_W'(magInt) << (MAN_W - INT_W);
    manOut  = aligned << lzCount;
    expOut  = zeroOut ? EXP_W'(1) : (EXP_W'(TOP_E) - EXP_W'(lzCount));
  end

endmodule

// File: rtl/flt_cmp_ctrl.sv
module flt_cmp_ctrl
  import flt_cmp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        popSel,
  output ctrlStrobe_t strobe,
  output logic        resValid
);

  always_comb begin
    strobe.load  = start;
    strobe.doPop = start & popSel;
  end

  always_ff @(posedge clk) begin
    if (rst) resValid <= 1'b0;
    else     resValid <= start;
  end

endmodule

// File: rtl/flt_cmp_dp.sv
module flt_cmp_dp
  import flt_cmp_pkg::*;
#(
  parameter int EXP_W    = 15,
  parameter int MAN_W    = 64,
  parameter int INT_W    = 32,
  parameter int NARROW_W = 16,
  localparam int STV_W   = 1 + EXP_W + MAN_W,
  localparam int KEY_W   = EXP_W + MAN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobe_t      strobe,
  input  logic [STV_W-1:0] stValue,
  input  logic             stEmpty,
  input  logic [2:0]       topIn,
  input  logic [INT_W-1:0] intOperand,
  input  logic             wideSel,
  output logic [2:0]       codeOut,
  output logic             exInvalid,
  output logic             exDenormal,
  output logic             exUnderflow,
  output logic             popReq,
  output logic [2:0]       nextTop
);

  logic             fSignRaw;
  logic [EXP_W-1:0] fExp;
  logic [MAN_W-1:0] fMan;
  fltClass_t        fCls;
  logic [EXP_W-1:0] fEffExp;

  logic             iNeg;
  logic             iZero;
  logic [EXP_W-1:0] iExp;
  logic [MAN_W-1:0] iMan;

  assign fSignRaw = stValue[STV_W-1];
  assign fExp     = stValue[STV_W-2 -: EXP_W];
  assign fMan     = stValue[MAN_W-1:0];

  flt_cmp_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_class (
    .expIn (fExp),
    .manIn (fMan),
    .cls   (fCls),
    .effExp(fEffExp)
  );

  flt_cmp_widen #(
    .EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W), .NARROW_W(NARROW_W)
  ) u_widen (
    .rawInt (intOperand),
    .wideSel(wideSel),
    .negOut (iNeg),
    .zeroOut(iZero),
    .expOut (iExp),
    .manOut (iMan)
  );

  logic             fSign;
  logic             iSign;
  logic [KEY_W-1:0] keyF;
  logic [KEY_W-1:0] keyI;
  cmpCode_t         ordCode;
  cmpCode_t         nextCode;
  logic             nextInv;
  logic             nextDen;

  // Ordered relation: signs first, then a magnitude key of {exponent, significand}.
  always_comb begin
    fSign = (fCls == CLS_ZERO) ? 1'b0 : fSignRaw;
    iSign = iZero ? 1'b0 : iNeg;
    keyF  = {fEffExp, fMan};
    keyI  = {iExp, iMan};
    if (fSign != iSign) begin
      ordCode = fSign ? CODE_LT : CODE_GT;
    end else if (keyF == keyI) begin
      ordCode = CODE_EQ;
    end else if ((keyF > keyI) ^ fSign) begin
      ordCode = CODE_GT;
    end else begin
      ordCode = CODE_LT;
    end
  end

  always_comb begin
    nextInv = 1'b0;
    nextDen = 1'b0;
    if (stEmpty) begin
      nextCode = CODE_UN;
    end else if (fCls == CLS_NAN || fCls == CLS_UNSUP) begin
      nextCode = CODE_UN;
      nextInv  = 1'b1;
    end else begin
      nextCode = ordCode;
      nextDen  = (fCls == CLS_DENORM);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      codeOut     <= '0;
      exInvalid   <= 1'b0;
      exDenormal  <= 1'b0;
      exUnderflow <= 1'b0;
      popReq      <= 1'b0;
      nextTop     <= '0;
    end else begin
      popReq <= strobe.doPop;
      if (strobe.load) begin
        codeOut     <= nextCode;
        exInvalid   <= nextInv;
        exDenormal  <= nextDen;
        exUnderflow <= stEmpty;
        nextTop     <= strobe.doPop ? topIn + 3'd1 : topIn;
      end
    end
  end

endmodule

// File: rtl/flt_int_cmp.sv
module flt_int_cmp
  import flt_cmp_pkg::*;
#(
  parameter int EXP_W    = 15,
  parameter int MAN_W    = 64,
  parameter int INT_W    = 32,
  parameter int NARROW_W = 16,
  localparam int STV_W   = 1 + EXP_W + MAN_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [STV_W-1:0] stValue,
  input  logic             stEmpty,
  input  logic [2:0]       topIn,
  input  logic [INT_W-1:0] intOperand,
  input  logic             wideSel,
  input  logic             popSel,
  output logic             resValid,
  output logic             condC3,
  output logic             condC2,
  output logic             condC1,
  output logic             condC0,
  output logic             exInvalid,
  output logic             exDenormal,
  output logic             exUnderflow,
  output logic             popReq,
  output logic [2:0]       nextTop
);

  ctrlStrobe_t strobe;
  logic [2:0]  codeOut;

  flt_cmp_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .popSel  (popSel),
    .strobe  (strobe),
    .resValid(resValid)
  );

  flt_cmp_dp #(
    .EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W), .NARROW_W(NARROW_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .stValue    (stValue),
    .stEmpty    (stEmpty),
    .topIn      (topIn),
    .intOperand (intOperand),
    .wideSel    (wideSel),
    .codeOut    (codeOut),
    .exInvalid  (exInvalid),
    .exDenormal (exDenormal),
    .exUnderflow(exUnderflow),
    .popReq     (popReq),
    .nextTop    (nextTop)
  );

  assign condC3 = codeOut[2];
  assign condC2 = codeOut[1];
  assign condC0 = codeOut[0];
  assign condC1 = 1'b0;

endmodule

// File: rtl/flt_int_cmp_chk.sv
module flt_int_cmp_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       stEmpty,
  input logic       popSel,
  input logic [2:0] topIn,
  input logic       resValid,
  input logic       condC3,
  input logic       condC2,
  input logic       condC0,
  input logic       exInvalid,
  input logic       exUnderflow,
  input logic       popReq,
  input logic [2:0] nextTop
);

  logic [2:0] code;
  assign code = {condC3, condC2, condC0};

  p_valid_after_start_r10: assert property (@(posedge clk) disable iff (rst)
    start |=> resValid);

  p_no_valid_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !start |=> !resValid);

  p_pop_needs_valid_r10: assert property (@(posedge clk) disable iff (rst)
    popReq |-> resValid);

  p_code_legal_r1: assert property (@(posedge clk) disable iff (rst)
    resValid |-> (code == 3'b000 || code == 3'b001 || code == 3'b100 || code == 3'b111));

  p_empty_flags_r6: assert property (@(posedge clk) disable iff (rst)
    start && stEmpty |=> exUnderflow && code == 3'b111 && !exInvalid);

  p_invalid_unordered_r3: assert property (@(posedge clk) disable iff (rst)
    resValid && exInvalid |-> code == 3'b111);

  p_pop_advance_r8: assert property (@(posedge clk) disable iff (rst)
    start && popSel |=> popReq && nextTop == 3'($past(topIn) + 3'd1));

  p_no_pop_hold_r8: assert property (@(posedge clk) disable iff (rst)
    start && !popSel |=> !popReq && nextTop == $past(topIn));

endmodule

bind flt_int_cmp flt_int_cmp_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .stEmpty    (stEmpty),
  .popSel     (popSel),
  .topIn      (topIn),
  .resValid   (resValid),
  .condC3     (condC3),
  .condC2     (condC2),
  .condC0     (condC0),
  .exInvalid  (exInvalid),
  .exUnderflow(exUnderflow),
  .popReq     (popReq),
  .nextTop    (nextTop)
);

// File: tb/flt_int_cmp_tb.sv
`timescale 1ns/1ps
module flt_int_cmp_tb;

  localparam int EXP_W    = 4;
  localparam int MAN_W    = 8;
  localparam int INT_W    = 8;
  localparam int NARROW_W = 4;
  localparam int STV_W    = 1 + EXP_W + MAN_W;
  localparam int SCALE    = 13;  // value * 2^SCALE is an integer for every encoding

  logic             clk = 1'b0;
  logic             rst;
  logic             start;
  logic [STV_W-1:0] stValue;
  logic             stEmpty;
  logic [2:0]       topIn;
  logic [INT_W-1:0] intOperand;
  logic             wideSel;
  logic             popSel;
  logic             resValid, condC3, condC2, condC1, condC0;
  logic             exInvalid, exDenormal, exUnderflow, popReq;
  logic [2:0]       nextTop;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  flt_int_cmp #(
    .EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W), .NARROW_W(NARROW_W)
  ) u_dut (
    .clk(clk), .rst(rst), .start(start), .stValue(stValue), .stEmpty(stEmpty),
    .topIn(topIn), .intOperand(intOperand), .wideSel(wideSel), .popSel(popSel),
    .resValid(resValid), .condC3(condC3), .condC2(condC2), .condC1(condC1),
    .condC0(condC0), .exInvalid(exInvalid), .exDenormal(exDenormal),
    .exUnderflow(exUnderflow), .popReq(popReq), .nextTop(nextTop)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Drives one compare at a falling edge and checks the registered result one cycle later.
  task automatic runOne(input logic [STV_W-1:0] fv, input logic [INT_W-1:0] iv,
                        input logic wide, input logic empty, input logic pop,
                        input logic [2:0] top);
    logic       s;
    logic [3:0] e;
    logic [7:0] m;
    longint     fmag, fval, ival;
    logic [2:0] eCode;
    logic       eInv, eDen;
    string      tag;
    stValue = fv; intOperand = iv; wideSel = wide; stEmpty = empty;
    popSel = pop; topIn = top; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    s = fv[12]; e = fv[11:8]; m = fv[7:0];
    ival = wide ? longint'($signed(iv)) : longint'($signed(iv[3:0]));
    fmag = (e == 4'd0) ? longint'(m) : (longint'(m) << (e - 4'd1));
    fval = s ? -fmag : fmag;
    eInv = 1'b0; eDen = 1'b0;
    if (empty) begin
      eCode = 3'b111; tag = "R6";
    end else if (e != 4'd0 && !m[7]) begin
      eCode = 3'b111; eInv = 1'b1; tag = "R3";
    end else if (e == 4'hF && m[6:0] != 7'd0) begin
      eCode = 3'b111; eInv = 1'b1; tag = "R3";
    end else if (e == 4'hF) begin
      eCode = s ? 3'b001 : 3'b000; tag = "R9";
    end else begin
      eDen = (e == 4'd0 && m != 8'd0);
      if (fval > (ival <<< SCALE))       eCode = 3'b000;
      else if (fval < (ival <<< SCALE))  eCode = 3'b001;
      else                               eCode = 3'b100;
      if (eDen)                              tag = "R5";
      else if (fmag == 0 && ival == 0)       tag = "R4";
      else if (!wide || iv == 8'h80)         tag = "R2";
      else                                   tag = "R1";
    end
    check(tag, {28'd0, condC3, condC2, condC0, exInvalid},
               {28'd0, eCode, eInv});
    check(tag, {30'd0, exDenormal, exUnderflow}, {30'd0, eDen, empty});
    check("R7", {31'd0, condC1}, 32'd0);
    check("R8", {28'd0, popReq, nextTop}, {28'd0, pop, 3'(top + {2'd0, pop})});
    check("R10", {31'd0, resValid}, 32'd1);
  endtask

  function automatic logic [INT_W-1:0] nearInt(input logic [STV_W-1:0] fv);
    logic [3:0] e;
    longint     q;
    e = fv[11:8];
    if (e == 4'hF) return 8'd0;
    q = ((e == 4'd0) ? longint'(fv[7:0]) : (longint'(fv[7:0]) << (e - 4'd1))) >> SCALE;
    if (fv[12]) q = -q;
    if (q > 127)  q = 127;
    if (q < -128) q = -128;
    return 8'(q);
  endfunction

  initial begin
    #(5.0 * 190000);
    bad++; total++;
    $display("FAIL R10 watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [STV_W-1:0] specials [10];
    rst = 1'b1; start = 1'b0; stValue = '0; stEmpty = 1'b0; topIn = 3'd0;
    intOperand = '0; wideSel = 1'b1; popSel = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state of every output
    check("R10", {22'd0, resValid, condC3, condC2, condC1, condC0, exInvalid,
                  exDenormal, exUnderflow, popReq, nextTop}, 32'd0);
    rst = 1'b0;

    // Sweep every stack encoding against extremes, zero, its own integer part and narrow operands.
    for (int f = 0; f < (1 << STV_W); f++) begin
      runOne(STV_W'(f), 8'h00, 1'b1, 1'b0, f[0], 3'(f >> 1));
      runOne(STV_W'(f), 8'h80, 1'b1, 1'b0, f[1], 3'(f >> 2));
      runOne(STV_W'(f), 8'h7F, 1'b1, 1'b0, 1'b0, 3'(f));
      runOne(STV_W'(f), nearInt(STV_W'(f)), 1'b1, 1'b0, f[2], 3'(f));
      runOne(STV_W'(f), 8'(f * 37), 1'b0, 1'b0, 1'b1, 3'(f >> 3));
      if (f % 97 == 0) runOne(STV_W'(f), 8'(f), 1'b1, 1'b1, f[0], 3'(f));
    end

    // Every integer pattern in both widths against fixed stack values.
    specials[0] = 13'h0000;                      // +0
    specials[1] = 13'h1000;                      // -0
    specials[2] = {1'b0, 4'hF, 8'h80};           // +inf
    specials[3] = {1'b1, 4'hF, 8'h80};           // -inf
    specials[4] = {1'b0, 4'hF, 8'hC0};           // NaN
    specials[5] = {1'b0, 4'h0, 8'h01};           // denormal
    specials[6] = {1'b0, 4'h7, 8'h80};           // +1
    specials[7] = {1'b1, 4'h7, 8'h80};           // -1
    specials[8] = {1'b0, 4'hE, 8'h80};           // +128
    specials[9] = {1'b1, 4'hE, 8'h80};           // -128
    for (int i = 0; i < 256; i++) begin
      for (int w = 0; w < 2; w++) begin
        for (int k = 0; k < 10; k++) begin
          runOne(specials[k], 8'(i), w[0], 1'b0, k[0], 3'(i + k));
        end
      end
    end

    // R10: no strobe means no valid and no pop
    start = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R10", {30'd0, resValid, popReq}, 32'd0);

    // R10: reset wins over a pending strobe and clears outputs
    stValue = {1'b1, 4'hF, 8'hC0}; stEmpty = 1'b1; popSel = 1'b1; topIn = 3'd5;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R10", {22'd0, resValid, condC3, condC2, condC1, condC0, exInvalid,
                  exDenormal, exUnderflow, popReq, nextTop}, 32'd0);
    start = 1'b0;
    rst = 1'b0;
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule